// File: doc/BRIEF.md
# Two-Dimensional Parity Error-Correction Engine

This block is a small register-mapped engine that a 16-bit host uses to guard a 64-bit data block with a two-dimensional parity code. The data bits are laid out as an 8x8 array, with bit index = row*8 + col. The check code holds one parity bit for each row and one for each column. The host writes the block as four 16-bit words. It writes the received check code into its own register. It then starts one of three operations: build the check code, compute the syndrome, or correct. When the engine is ready again, the host reads back the result, the possibly repaired data and a status word.

The host sequence is fixed. First it waits for `ready` to be high. Then it writes the words and issues the command. Then it reads the results. A single flipped data bit is located from the crossing of one row syndrome bit and one column syndrome bit, and it is repaired in place. A single flipped check bit is repaired in the check register. Any other non-zero syndrome is reported as uncorrectable and changes nothing. The array dimensions are parameters. The data width, the number of words and the register addresses all follow from them.

Top module: `parity2d_ecc`

## Requirements
- R1: After a synchronous reset, every readable register (data words, check register, status, result) reads zero and `ready` is 1.
- R2: Writes are accepted only while `ready` is 1. Addresses 0..3 take data words, least significant word first (address k holds data bits 16k+15..16k). Address 4 takes the check code. Addresses 5..7 ignore writes. `rd_data` shows the register at `rd_addr` one clock later. Address 5 reads the status, address 6 reads the result, and address 7 reads zero.
- R3: Command 2'b01 (encode) computes the code and stores it both in the check register and in the result. Bit r of the code is the XOR of data bits r*8..r*8+7. Bit 8+c is the XOR of data bits c, c+8, ..., c+56. The status is cleared.
- R4: Command 2'b10 (syndrome) stores in the result the check register XORed with the code recomputed from the data. The data and the check register are left unchanged.
- R5: A zero syndrome gives a status of zero.
- R6: A syndrome with exactly one row bit r and one column bit c set marks a data error. The status has bit 0 (detected) set, and bits 13:8 hold r*8+c. Command 2'b11 (correct) also flips that data bit and sets bit 1 (corrected).
- R7: A syndrome with exactly one bit set marks a check-bit error. The status has the detected bit set and its index field set to zero. Under the correct command the check register bit is repaired, the data is left unchanged and the corrected bit is set.
- R8: Any other non-zero syndrome sets status bits 0 and 2 (detected, uncorrectable). The data and the check register are left unchanged.
- R9: An accepted command drops `ready` for exactly one cycle. The results are readable once `ready` is high again.
- R10: Command 2'b00 is ignored, and `ready` stays high. Commands and writes presented while `ready` is low are ignored.
- R11: The corrected and uncorrectable flags are never set together. Either of them implies the detected flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 2 | Operation: 01 encode, 10 syndrome, 11 correct |
| ready | output | 1 | Engine idle and accepting writes and commands |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |

## Verification
The hardest cases to reach from the ports are the mixed double faults. One example is a flipped data bit together with a flipped parity bit of its own row. The syndrome then shows one lone column bit, and the engine takes it for a check-bit fault. The random phase builds these cases on purpose. It encodes random data, then flips zero, one or two distinct positions drawn from all 80 data and check bits, and compares every register after a correct command with a bench model of the decode rules. Directed cases cover the corner bits 0 and 63, a single check bit, a same-row double fault, a write issued while the engine is busy, and the idle command.

// File: rtl/parity2d_pkg.sv
package parity2d_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ENC  = 2'b01,
    OP_SYN  = 2'b10,
    OP_COR  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SC_CLEAN,
    SC_DATA,
    SC_CHECK,
    SC_MULTI
  } syn_class_e;

  // status word bit positions
  localparam int unsigned ST_DET = 0;
  localparam int unsigned ST_COR = 1;
  localparam int unsigned ST_UNC = 2;
  localparam int unsigned ST_IDX = 8;
endpackage

// File: rtl/parity2d_gen.sv
module parity2d_gen #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int DATA_W = ROWS * COLS,
  localparam int CHK_W  = ROWS + COLS
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  code
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign code[r] = ^data[r*COLS +: COLS];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] slice;
    for (genvar r = 0; r < ROWS; r++) begin : g_bit
      assign slice[r] = data[r*COLS + c];
    end
    assign code[ROWS + c] = ^slice;
  end
endmodule

// File: rtl/parity2d_decode.sv
module parity2d_decode
  import parity2d_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int CHK_W = ROWS + COLS,
  localparam int IDX_W = $clog2(ROWS * COLS)
) (
  input  logic [CHK_W-1:0] syn,
  output syn_class_e       cls,
  output logic [IDX_W-1:0] idx
);
  int rcnt, ccnt, rpos, cpos, lin;

  always_comb begin
    rcnt = 0;
    ccnt = 0;
    rpos = 0;
    cpos = 0;
    for (int r = 0; r < ROWS; r++) begin
      if (syn[r]) begin
        rcnt = rcnt + 1;
        rpos = r;
      end
    end
    for (int c = 0; c < COLS; c++) begin
      if (syn[ROWS + c]) begin
        ccnt = ccnt + 1;
        cpos = c;
      end
    end
    lin = rpos * COLS + cpos;
    if (rcnt == 0 && ccnt == 0) begin
      cls = SC_CLEAN;
    end else if (rcnt == 1 && ccnt == 1) begin
      cls = SC_DATA;
    end else if (rcnt + ccnt == 1) begin
      cls = SC_CHECK;
    end else begin
      cls = SC_MULTI;
    end
    idx = (cls == SC_DATA) ? lin[IDX_W-1:0] : '0;
  end
endmodule

// File: rtl/parity2d_ecc.sv
module parity2d_ecc
  import parity2d_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int WORD_W = 16,
  localparam int DATA_W = ROWS * COLS,
  localparam int CHK_W  = ROWS + COLS,
  localparam int NWORDS = DATA_W / WORD_W,
  localparam int ADDR_W = $clog2(NWORDS + 3),
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd,
  output logic              ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] A_CHK  = ADDR_W'(NWORDS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NWORDS + 1);
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(NWORDS + 2);

  logic [DATA_W-1:0] data_q;
  logic [CHK_W-1:0]  chk_q;
  logic [WORD_W-1:0] stat_q, res_q, rd_q;
  logic              ready_q;
  op_e               op_q;

  logic [CHK_W-1:0]  calc;
  logic [CHK_W-1:0]  syn;
  syn_class_e        dec_cls;
  logic [IDX_W-1:0]  dec_idx;
  logic [WORD_W-1:0] stat_nx;
  logic [WORD_W-1:0] rd_mux;

  parity2d_gen #(.ROWS(ROWS), .COLS(COLS)) u_gen (
    .data(data_q),
    .code(calc)
  );

  assign syn = chk_q ^ calc;

  parity2d_decode #(.ROWS(ROWS), .COLS(COLS)) u_dec (
    .syn(syn),
    .cls(dec_cls),
    .idx(dec_idx)
  );

  always_comb begin
    stat_nx = '0;
    stat_nx[ST_DET] = (dec_cls != SC_CLEAN);
    stat_nx[ST_UNC] = (dec_cls == SC_MULTI);
    stat_nx[ST_COR] = (op_q == OP_COR) && (dec_cls == SC_DATA || dec_cls == SC_CHECK);
    stat_nx[ST_IDX +: IDX_W] = dec_idx;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr < A_CHK) begin
      rd_mux = data_q[int'(rd_addr)*WORD_W +: WORD_W];
    end else if (rd_addr == A_CHK) begin
      rd_mux = WORD_W'(chk_q);
    end else if (rd_addr == A_STAT) begin
      rd_mux = stat_q;
    end else if (rd_addr == A_RES) begin
      rd_mux = res_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      chk_q   <= '0;
      stat_q  <= '0;
      res_q   <= '0;
      rd_q    <= '0;
      ready_q <= 1'b1;
      op_q    <= OP_NONE;
    end else begin
      rd_q <= rd_mux;
      if (ready_q) begin
        if (wr_en) begin
          if (wr_addr < A_CHK) begin
            data_q[int'(wr_addr)*WORD_W +: WORD_W] <= wr_data;
          end else if (wr_addr == A_CHK) begin
            chk_q <= wr_data[CHK_W-1:0];
          end
        end
        if (cmd_valid && op_e'(cmd) != OP_NONE) begin
          op_q    <= op_e'(cmd);
          ready_q <= 1'b0;
        end
      end else begin
        ready_q <= 1'b1;
        if (op_q == OP_ENC) begin
          chk_q  <= calc;
          res_q  <= WORD_W'(calc);
          stat_q <= '0;
        end else begin
          res_q  <= WORD_W'(syn);
          stat_q <= stat_nx;
          if (op_q == OP_COR) begin
            if (dec_cls == SC_DATA) begin
              data_q <= data_q ^ (DATA_W'(1) << dec_idx);
            end else if (dec_cls == SC_CHECK) begin
              chk_q <= chk_q ^ syn;
            end
          end
        end
      end
    end
  end

  assign ready   = ready_q;
  assign rd_data = rd_q;

  // R9
  ready_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !ready_q |=> ready_q);

  // R10
  idle_op_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_q && cmd_valid && cmd == 2'b00) |=> ready_q);

  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_q && wr_en && op_q != OP_COR) |=> data_q == $past(data_q));

  // R8
  multi_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_q && op_q == OP_COR && dec_cls == SC_MULTI)
      |=> (data_q == $past(data_q)) && (chk_q == $past(chk_q)));

  // R11
  flag_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(stat_q[ST_COR] && stat_q[ST_UNC]));

  // R11
  flag_implies_det_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q[ST_COR] || stat_q[ST_UNC]) |-> stat_q[ST_DET]);
endmodule

// File: tb/parity2d_ecc_bench.sv
module parity2d_ecc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd = '0;
  logic        ready;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [63:0] m_data;
  logic [15:0] m_chk, m_stat, m_res;

  always #10 clk = ~clk;

  parity2d_ecc u_parity2d_ecc (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd(cmd), .ready(ready), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [15:0] f_code(logic [63:0] d);
    logic [15:0] k = '0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        k[r]     = k[r] ^ d[r*8 + c];
        k[8 + c] = k[8 + c] ^ d[r*8 + c];
      end
    return k;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [2:0] a, logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic load(logic [63:0] d, logic [15:0] k);
    for (int w = 0; w < 4; w++) do_write(3'(w), d[w*16 +: 16]);
    do_write(3'd4, k);
    m_data = d;
    m_chk  = k;
  endtask

  task automatic model_exec(logic [1:0] op);
    logic [15:0] code, syn, st;
    int rc, cc, rp, cp;
    code = f_code(m_data);
    if (op == 2'b01) begin
      m_chk = code; m_res = code; m_stat = '0;
    end else begin
      syn = m_chk ^ code;
      m_res = syn;
      rc = 0; cc = 0; rp = 0; cp = 0;
      for (int i = 0; i < 8; i++) begin
        if (syn[i])     begin rc++; rp = i; end
        if (syn[8 + i]) begin cc++; cp = i; end
      end
      st = '0;
      if (syn != 0) st[0] = 1'b1;
      if (rc == 1 && cc == 1) begin
        st[13:8] = 6'(rp*8 + cp);
        if (op == 2'b11) begin
          m_data[rp*8 + cp] = ~m_data[rp*8 + cp];
          st[1] = 1'b1;
        end
      end else if (rc + cc == 1) begin
        if (op == 2'b11) begin
          m_chk = m_chk ^ syn;
          st[1] = 1'b1;
        end
      end else if (syn != 0) begin
        st[2] = 1'b1;
      end
      m_stat = st;
    end
  endtask

  // R9: ready low exactly one cycle
  task automatic do_cmd(logic [1:0] c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R9 busy", 16'(ready), 16'd0);
    @(negedge clk);
    check("R9 ready back", 16'(ready), 16'd1);
    model_exec(c);
  endtask

  task automatic check_all(string req);
    logic [15:0] v;
    for (int w = 0; w < 4; w++) begin
      do_read(3'(w), v);
      check({req, " data"}, v, m_data[w*16 +: 16]);
    end
    do_read(3'd4, v); check({req, " check"}, v, m_chk);
    do_read(3'd5, v); check({req, " status"}, v, m_stat);
    do_read(3'd6, v); check({req, " result"}, v, m_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [63:0] d, base;
    void'($urandom(32'd1234));
    m_data = '0; m_chk = '0; m_stat = '0; m_res = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready", 16'(ready), 16'd1);
    check_all("R1");
    do_read(3'd7, v); check("R2 addr7", v, 16'd0);

    // R2 R3: encode a known pattern
    base = 64'h0123_4567_89AB_CDEF;
    load(base, 16'h0000);
    do_write(3'd5, 16'hFFFF);
    do_write(3'd6, 16'hFFFF);
    check_all("R2");
    do_cmd(2'b01);
    check_all("R3");

    // R4 R5: clean syndrome
    do_cmd(2'b10);
    check_all("R5");

    // R6: bit 0 then bit 63
    load(base ^ 64'h1, m_chk);
    do_cmd(2'b10);
    check_all("R4 R6 syn bit0");
    do_cmd(2'b11);
    check_all("R6 cor bit0");
    check("R6 restored", m_data[15:0], base[15:0]);
    load(base ^ (64'h1 << 63), m_chk);
    do_cmd(2'b11);
    check_all("R6 cor bit63");

    // R7: check bit 11 flipped
    load(base, f_code(base) ^ 16'h0800);
    do_cmd(2'b11);
    check_all("R7");
    check("R7 repaired", m_chk, f_code(base));

    // R8: two bits in the same row
    load(base ^ 64'h24, f_code(base));
    do_cmd(2'b11);
    check_all("R8");

    // R10: idle command ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 2'b00;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 idle cmd", 16'(ready), 16'd1);
    check_all("R10 idle");

    // R10: write while busy ignored
    load(base, f_code(base));
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 2'b01;
    @(negedge clk);
    cmd_valid = 1'b0;
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 16'hDEAD;
    @(negedge clk);
    wr_en = 1'b0;
    model_exec(2'b01);
    check_all("R10 busy write");

    // random: encode, inject 0..2 faults, correct (R6 R7 R8 R11)
    for (int it = 0; it < 60; it++) begin
      int nf, p0, p1;
      logic [15:0] k;
      d = {$urandom(), $urandom()};
      load(d, 16'h0000);
      do_cmd(2'b01);
      check("R3 rand code", m_chk, f_code(d));
      nf = $urandom_range(0, 2);
      p0 = $urandom_range(0, 79);
      p1 = (p0 + $urandom_range(1, 79)) % 80;
      k = m_chk;
      if (nf >= 1) begin
        if (p0 < 64) d[p0] = ~d[p0]; else k[p0-64] = ~k[p0-64];
      end
      if (nf == 2) begin
        if (p1 < 64) d[p1] = ~d[p1]; else k[p1-64] = ~k[p1-64];
      end
      load(d, k);
      do_cmd(2'b11);
      check_all("R11 rand");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule